// File: doc/BRIEF.md
# PCI Target Configuration Register File

This block holds the type-0 configuration header of a PCI target agent. A host reaches it through a simple register port. Each access carries a dword offset into the 256-byte space, four byte enables, write data and a read strobe. A device-select qualifier plays the role of the per-slot select line: while it is low, the block ignores writes and returns all ones on reads, which is how an empty slot looks to bus enumeration.

The header exposes the following:

- Fixed identity fields: vendor, device, revision and class code.
- A command register whose memory-space and bus-master bits leave the block as enables.
- A cache line size register that keeps only one legal value.
- A read/write latency timer.
- Interrupt-pin and minimum-grant fields, both reading zero.
- Four memory base address registers. One maps the control-register window; three map memory windows.

Each base address register has a fixed set of writable bits, derived from its window size. Because of this, writing all ones and reading back gives the size of the window. The programmed bases leave the block so that the rest of the device can decode incoming addresses.

Top module: `cfg_space`

## Requirements
- R1: Dword offset 0 reads {device ID, vendor ID}, with the vendor ID in bits 15:0. Offset 2 reads {class code, revision ID}, with the revision ID in bits 7:0. Writes to both offsets have no effect.
- R2: While dev_sel is low, a read returns 0xFFFFFFFF and a write changes no register.
- R3: At offset 1, bit 1 of the command register enables memory-space decode and drives mem_space_en. Bit 2 enables bus mastering and drives bus_master_en. Only these two bits are writable. Every other command bit and the whole status half (bits 31:16) read 0.
- R4: The cache line size is held in bits 7:0 of offset 3. Writing 8 stores 8. Writing any other value stores 0.
- R5: The latency timer is held in bits 15:8 of offset 3 and accepts all 8 bits. Offset 15 (byte address 0x3C) reads 0, so both the interrupt pin (bits 15:8) and the minimum grant (bits 23:16) are zero.
- R6: Base address registers sit at offsets 4 (control window), 5, 6 and 7 (memory windows 0 to 2). After an all-ones write, a register reads back ~(size-1) with bits 3:0 at 0. With the default sizes, the readbacks are 0xFE000000, 0xFFF80000, 0xFF000000 and 0xF0000000.
- R7: A written base appears, masked to its decoded bits, on ctl_win_base and on mem_win_base. On mem_win_base, window n occupies bits 32n+31:32n.
- R8: A write changes only the bytes whose enable bit is set. cfg_be[k] covers bits 8k+7:8k.
- R9: Read data and cfg_rvalid appear one clock after the cycle in which cfg_rd is high. cfg_rvalid lasts one cycle.
- R10: After reset, all writable fields are 0, so both enables are low and all bases are 0.
- R11: Offsets that hold no register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_sel | input | 1 | Device-select qualifier for the access |
| cfg_wr | input | 1 | Write strobe |
| cfg_rd | input | 1 | Read strobe |
| cfg_dw_off | input | 6 | Dword offset into the 256-byte space |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data |
| cfg_rvalid | output | 1 | Read data valid, one cycle |
| mem_space_en | output | 1 | Memory-space enable (command bit 1) |
| bus_master_en | output | 1 | Bus-master enable (command bit 2) |
| ctl_win_base | output | 32 | Control-window base address |
| mem_win_base | output | 96 | Memory-window bases, window n at bits 32n+31:32n |

## Verification
The sizing function is exercised in three ways.

- An all-ones write to each of the four base registers, each of a different size. This separates a correct per-register mask from one shared or shifted by one bit.
- An arbitrary address containing bits below the window size. This shows that low bits are dropped on the output ports as well as on readback.
- Byte-lane-restricted writes. These show that the lane enables and the fixed mask combine, rather than one overriding the other.

The cache line size register is written with its legal value and with an illegal one. Deselected reads and writes are issued against registers that already hold non-zero values, so that a block ignoring dev_sel is seen to change them.

// File: rtl/cfg_space_pkg.sv
package cfg_space_pkg;

    localparam int unsigned DW = 32;
    localparam int unsigned OFFW = 6;
    localparam int unsigned NBAR = 4;

    localparam logic [OFFW-1:0] OFF_ID = 6'd0;
    localparam logic [OFFW-1:0] OFF_CMD = 6'd1;
    localparam logic [OFFW-1:0] OFF_CLASS = 6'd2;
    localparam logic [OFFW-1:0] OFF_MISC = 6'd3;
    localparam logic [OFFW-1:0] OFF_BAR0 = 6'd4;

    typedef struct packed {
        logic [DW-1:0] base;
    } bar_state_t;

    typedef struct packed {
        logic mem_en;
        logic mst_en;
        logic [7:0] cls;
        logic [7:0] lat;
    } ctrl_state_t;

    typedef struct packed {
        logic [DW-1:0] rdata;
        logic rvalid;
    } rd_state_t;

    function automatic logic [DW-1:0] lane_mask(input logic [3:0] be);
        return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    endfunction

endpackage

// File: rtl/cfg_bar.sv
module cfg_bar
    import cfg_space_pkg::*;
#(
    parameter int unsigned SZ_LOG2 = 19
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_hit,
    input  logic [3:0]    be,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] base
);
    localparam logic [DW-1:0] ADDR_MASK = ~((32'd1 << SZ_LOG2) - 32'd1);

    bar_state_t st_d, st_q;
    logic [DW-1:0] wmask;

    always_comb begin
        st_d  = st_q;
        wmask = lane_mask(be) & ADDR_MASK;
        if (wr_hit) begin
            st_d.base = (st_q.base & ~wmask) | (wdata & wmask);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign base = st_q.base;

    a_r8_bar_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_hit) |-> $stable(st_q.base));
    a_r8_top_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !be[3]) |=> st_q.base[31:24] == $past(st_q.base[31:24]));

endmodule

// File: rtl/cfg_ctrl_regs.sv
module cfg_ctrl_regs
    import cfg_space_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [OFFW-1:0] dw_off,
    input  logic [1:0]      be,
    input  logic [15:0]     wdata,
    output logic            mem_en,
    output logic            mst_en,
    output logic [7:0]      cls,
    output logic [7:0]      lat
);
    localparam logic [7:0] CLS_LEGAL = 8'd8;

    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && dw_off == OFF_CMD && be[0]) begin
            st_d.mem_en = wdata[1];
            st_d.mst_en = wdata[2];
        end
        if (wr_en && dw_off == OFF_MISC) begin
            if (be[0]) st_d.cls = (wdata[7:0] == CLS_LEGAL) ? CLS_LEGAL : 8'd0;
            if (be[1]) st_d.lat = wdata[15:8];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mem_en = st_q.mem_en;
    assign mst_en = st_q.mst_en;
    assign cls    = st_q.cls;
    assign lat    = st_q.lat;

    a_r4_cls_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cls == 8'd0) || (st_q.cls == CLS_LEGAL));
    a_r3_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> ($stable(st_q.mem_en) && $stable(st_q.mst_en)));

endmodule

// File: rtl/cfg_space.sv
module cfg_space
    import cfg_space_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID = 16'h1A2B,
    parameter logic [15:0] DEVICE_ID = 16'h3C4D,
    parameter logic [7:0]  REV_ID = 8'h01,
    parameter logic [23:0] CLASS_CODE = 24'h0B4000,
    parameter int unsigned CTL_SZ_LOG2 = 25,
    parameter int unsigned WIN0_SZ_LOG2 = 19,
    parameter int unsigned WIN1_SZ_LOG2 = 24,
    parameter int unsigned WIN2_SZ_LOG2 = 28
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dev_sel,
    input  logic          cfg_wr,
    input  logic          cfg_rd,
    input  logic [5:0]    cfg_dw_off,
    input  logic [3:0]    cfg_be,
    input  logic [31:0]   cfg_wdata,
    output logic [31:0]   cfg_rdata,
    output logic          cfg_rvalid,
    output logic          mem_space_en,
    output logic          bus_master_en,
    output logic [31:0]   ctl_win_base,
    output logic [95:0]   mem_win_base
);
    localparam int unsigned BAR_LOG2 [NBAR] = '{CTL_SZ_LOG2, WIN0_SZ_LOG2, WIN1_SZ_LOG2, WIN2_SZ_LOG2};

    logic          wr_ok;
    logic [DW-1:0] bar_q [NBAR];
    logic [7:0]    cls, lat;
    logic          mem_en, mst_en;
    logic [DW-1:0] mux;
    rd_state_t     rd_d, rd_q;

    assign wr_ok = cfg_wr && dev_sel;

    cfg_ctrl_regs u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_ok),
        .dw_off (cfg_dw_off),
        .be     (cfg_be[1:0]),
        .wdata  (cfg_wdata[15:0]),
        .mem_en (mem_en),
        .mst_en (mst_en),
        .cls    (cls),
        .lat    (lat)
    );

    for (genvar g = 0; g < NBAR; g++) begin : g_bar
        cfg_bar #(.SZ_LOG2(BAR_LOG2[g])) u_bar (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_hit (wr_ok && cfg_dw_off == OFF_BAR0 + OFFW'(g)),
            .be     (cfg_be),
            .wdata  (cfg_wdata),
            .base   (bar_q[g])
        );
        if (g > 0) begin : g_out
            assign mem_win_base[32*(g-1) +: 32] = bar_q[g];
        end
    end

    assign ctl_win_base = bar_q[0];

    // Read-back multiplexer: identity, command, class, misc and BARs.
    always_comb begin
        mux = '0;
        case (cfg_dw_off)
            OFF_ID:    mux = {DEVICE_ID, VENDOR_ID};
            OFF_CMD:   mux = {16'h0000, 13'd0, mst_en, mem_en, 1'b0};
            OFF_CLASS: mux = {CLASS_CODE, REV_ID};
            OFF_MISC:  mux = {16'h0000, lat, cls};
            6'd4:      mux = bar_q[0];
            6'd5:      mux = bar_q[1];
            6'd6:      mux = bar_q[2];
            6'd7:      mux = bar_q[3];
            default:   mux = '0;
        endcase
    end

    always_comb begin
        rd_d        = rd_q;
        rd_d.rvalid = cfg_rd;
        if (cfg_rd) rd_d.rdata = dev_sel ? mux : '1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign cfg_rdata     = rd_q.rdata;
    assign cfg_rvalid    = rd_q.rvalid;
    assign mem_space_en  = mem_en;
    assign bus_master_en = mst_en;

    a_r9_valid_after_rd: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rvalid |-> $past(cfg_rd));
    a_r2_deselect_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rvalid && !$past(dev_sel)) |-> cfg_rdata == 32'hFFFF_FFFF);
    a_r1_id_read: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rvalid && $past(dev_sel) && $past(cfg_dw_off) == OFF_ID)
        |-> cfg_rdata == {DEVICE_ID, VENDOR_ID});
    a_r2_desel_no_bar_change: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!dev_sel) |-> ($stable(ctl_win_base) && $stable(mem_win_base)));

endmodule

// File: tb/sim_cfg_space.sv
module sim_cfg_space;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dev_sel = 1'b0, cfg_wr = 1'b0, cfg_rd = 1'b0;
    logic [5:0] cfg_dw_off = '0;
    logic [3:0] cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic cfg_rvalid, mem_space_en, bus_master_en;
    logic [31:0] ctl_win_base;
    logic [95:0] mem_win_base;
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cfg_space u0 (.*);

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [5:0] off, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        dev_sel = sel; cfg_wr = 1'b1; cfg_dw_off = off; cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0; dev_sel = 1'b0;
    endtask

    task automatic rd(input logic sel, input logic [5:0] off, output logic [31:0] d);
        @(negedge clk);
        dev_sel = sel; cfg_rd = 1'b1; cfg_dw_off = off;
        @(negedge clk);
        cfg_rd = 1'b0; dev_sel = 1'b0;
        d = cfg_rdata;
    endtask

    task automatic t_reset();
        check("R10 mem_en", {31'd0, mem_space_en}, 32'd0);
        check("R10 master_en", {31'd0, bus_master_en}, 32'd0);
        check("R10 ctl base", ctl_win_base, 32'd0);
        check("R10 win bases", mem_win_base[31:0] | mem_win_base[63:32] | mem_win_base[95:64], 32'd0);
        check("R10 rvalid", {31'd0, cfg_rvalid}, 32'd0);
    endtask

    task automatic t_ids();
        logic [31:0] d;
        rd(1'b1, 6'd0, d);
        check("R1 id", d, 32'h3C4D1A2B);
        check("R9 rvalid high", {31'd0, cfg_rvalid}, 32'd1);
        @(negedge clk);
        check("R9 rvalid one cycle", {31'd0, cfg_rvalid}, 32'd0);
        wr(1'b1, 6'd0, 4'hF, 32'h0);
        wr(1'b1, 6'd2, 4'hF, 32'h0);
        rd(1'b1, 6'd0, d); check("R1 id after write", d, 32'h3C4D1A2B);
        rd(1'b1, 6'd2, d); check("R1 class/rev", d, 32'h0B400001);
    endtask

    task automatic t_command();
        logic [31:0] d;
        wr(1'b1, 6'd1, 4'hF, 32'hFFFF_FFFF);
        check("R3 mem_en", {31'd0, mem_space_en}, 32'd1);
        check("R3 master_en", {31'd0, bus_master_en}, 32'd1);
        rd(1'b1, 6'd1, d); check("R3 cmd readback", d, 32'h0000_0006);
        wr(1'b1, 6'd1, 4'hF, 32'h0000_0004);
        check("R3 mem_en cleared", {31'd0, mem_space_en}, 32'd0);
        check("R3 master kept", {31'd0, bus_master_en}, 32'd1);
        wr(1'b1, 6'd1, 4'hF, 32'h0000_0006);
    endtask

    task automatic t_deselect();
        logic [31:0] d;
        rd(1'b0, 6'd0, d); check("R2 desel id read", d, 32'hFFFF_FFFF);
        rd(1'b0, 6'd1, d); check("R2 desel cmd read", d, 32'hFFFF_FFFF);
        wr(1'b0, 6'd1, 4'hF, 32'h0);
        check("R2 desel write mem_en", {31'd0, mem_space_en}, 32'd1);
        check("R2 desel write master_en", {31'd0, bus_master_en}, 32'd1);
    endtask

    task automatic t_cls_lat();
        logic [31:0] d;
        wr(1'b1, 6'd3, 4'h3, 32'h0000_4008);
        rd(1'b1, 6'd3, d); check("R4 cls legal / R5 lat", d, 32'h0000_4008);
        wr(1'b1, 6'd3, 4'h1, 32'h0000_0010);
        rd(1'b1, 6'd3, d); check("R4 cls illegal", d, 32'h0000_4000);
        wr(1'b1, 6'd3, 4'h2, 32'h0000_FF00);
        rd(1'b1, 6'd3, d); check("R5 lat full", d, 32'h0000_FF00);
        wr(1'b1, 6'd15, 4'hF, 32'hFFFF_FFFF);
        rd(1'b1, 6'd15, d); check("R5 pin and min grant zero", d, 32'h0);
    endtask

    task automatic t_bar_size();
        logic [31:0] d;
        logic [31:0] exp [4] = '{32'hFE000000, 32'hFFF80000, 32'hFF000000, 32'hF0000000};
        for (int i = 0; i < 4; i++) begin
            wr(1'b1, 6'(4 + i), 4'hF, 32'hFFFF_FFFF);
            rd(1'b1, 6'(4 + i), d);
            check($sformatf("R6 size bar%0d", i), d, exp[i]);
        end
    endtask

    task automatic t_bar_program();
        logic [31:0] d;
        wr(1'b1, 6'd5, 4'hF, 32'hC001_2345);
        check("R7 win0 port", mem_win_base[31:0], 32'hC000_0000);
        rd(1'b1, 6'd5, d); check("R7 win0 read", d, 32'hC000_0000);
        wr(1'b1, 6'd4, 4'hF, 32'h3000_0000);
        check("R7 ctl port", ctl_win_base, 32'h3000_0000);
        wr(1'b1, 6'd7, 4'hF, 32'hE000_0000);
        check("R7 win2 port", mem_win_base[95:64], 32'hE000_0000);
    endtask

    task automatic t_byte_en();
        logic [31:0] d;
        wr(1'b1, 6'd6, 4'hF, 32'h0);
        wr(1'b1, 6'd6, 4'h8, 32'hAAAA_AAAA);
        check("R8 top lane only", mem_win_base[63:32], 32'hAA00_0000);
        wr(1'b1, 6'd6, 4'h7, 32'h5555_5555);
        check("R8 disabled lane kept", mem_win_base[63:32], 32'hAA00_0000);
        wr(1'b1, 6'd1, 4'h2, 32'h0000_0000);
        check("R8 cmd lane1 ignored", {31'd0, mem_space_en}, 32'd1);
        rd(1'b1, 6'd9, d); check("R11 unimplemented", d, 32'h0);
        rd(1'b1, 6'd63, d); check("R11 last dword", d, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_ids();
        t_command();
        t_deselect();
        t_cls_lat();
        t_bar_size();
        t_bar_program();
        t_byte_en();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule